// File: doc/BRIEF.md
# GPIO Pad Controller with Event Trigger and Interrupt Routing

This block controls one general-purpose I/O pad. Two 32-bit configuration words set it up. The first word holds the pad's control fields: drive value, driver and receiver disables, pad mode, event trigger, receive inversion, interrupt routing and reset domain. The second word is stored unchanged and presented to the analog pad electricals. In GPIO mode the pad drives the stored output value. In native modes 1 to 6 the pad passes data and enable from one of six alternate functions, and the received level goes back to that function alone.

The pad input passes through a two-flop synchronizer. An optional inversion follows, and then an event detector that is built as a small state machine:

- `EV_IDLE`: trigger off or input disabled.
- `EV_LEVEL`: level trigger; the routed outputs follow the inverted input.
- `EV_ARMED`: edge trigger, waiting for an edge.
- `EV_LATCHED`: sticky status set.

Each state moves as follows:

- Any state goes to `EV_IDLE` when the trigger is off or the input is disabled.
- Any state goes to `EV_LEVEL` when the trigger is level.
- `EV_IDLE` and `EV_LEVEL` go to `EV_ARMED` when an edge trigger is selected.
- `EV_ARMED` goes to `EV_LATCHED` on a qualifying edge.
- `EV_LATCHED` goes to `EV_ARMED` on a clear pulse that does not coincide with a new edge.
- In every other case a state holds.

A detected event raises any mix of four interrupt outputs: non-maskable, system-management, system-control and APIC.

The configuration returns to its defaults on power-good reset. It also returns to its defaults on whichever of the other three reset sources the configuration selects.

Top module: `gpad_ctrl`

## Requirements
- R1: After power-good reset, word 0 reads 0x0400_0100 with the pad low: GPIO mode, output disabled, input enabled, trigger off, no routing, power-good domain. Word 1 reads 0, pad_oe is 0, all interrupts are 0 and evt_sts is 0.
- R2: In GPIO mode (word 0 bits [12:10] = 0), pad_out equals word 0 bit 0. pad_oe is 1 unless word 0 bit 8 (output disable) is set.
- R3: A mode of 1 to 6 in bits [12:10] routes nf_tx[mode-1] to pad_out and nf_oe[mode-1] to pad_oe, still subject to bit 8. Only nf_rx[mode-1] carries the received level. Mode 7 drives nothing and delivers nothing.
- R4: The received level is the pad input after two clock edges, forced to 0 while word 0 bit 9 (input disable) is set. Word 0 bit 1 reads this level. Writes to bit 1 and to the unused bits of word 0 are ignored, and those unused bits read 0.
- R5: With trigger 0 (level) in bits [26:25], each routed output equals the received level XOR bit 23 (invert).
- R6: Trigger 1 (single edge) sets evt_sts on a rising pad edge when bit 23 is 0, and on a falling pad edge when bit 23 is 1. An edge in the other direction has no effect. Status is visible three clock edges after the pad changes.
- R7: Trigger 3 (both edges) sets evt_sts on either pad edge.
- R8: evt_sts stays set until a sts_clr pulse. A new edge in the same cycle as the clear keeps it set.
- R9: Word 0 bits 17, 18, 19 and 20 enable irq_nmi, irq_smi, irq_sci and irq_apic respectively. Any combination may be set.
- R10: With trigger 2 (off) or with the input disabled, no status is set and no interrupt is raised. Switching into either condition clears a pending status.
- R11: Word 0 bits [31:30] select the reset that clears both words: 0 power-good only, 1 deep_rst_n, 2 plat_rst_n, 3 resume_rst_n. The unselected resets leave the configuration unchanged. Power-good reset always clears both words.
- R12: cfg_wr_sel picks the word a write lands in (0 word 0, 1 word 1). Word 1 is stored whole and appears on cfg_word1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrgood_rst_n | input | 1 | Power-good reset, asynchronous, active low |
| deep_rst_n | input | 1 | Deep reset, synchronous, active low |
| plat_rst_n | input | 1 | Platform reset, synchronous, active low |
| resume_rst_n | input | 1 | Resume-well reset, synchronous, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Word select for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_word0 | output | 32 | Word 0 readback with live received level in bit 1 |
| cfg_word1 | output | 32 | Word 1, also sent to pad electricals |
| sts_clr | input | 1 | Write-one-to-clear pulse for the event status |
| evt_sts | output | 1 | Sticky edge event status |
| pad_in | input | 1 | Asynchronous pad receive level |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad driver enable |
| nf_tx | input | 6 | Drive values from native functions 1..6 |
| nf_oe | input | 6 | Drive enables from native functions 1..6 |
| nf_rx | output | 6 | Received level to the selected native function |
| irq_nmi | output | 1 | Non-maskable interrupt request |
| irq_smi | output | 1 | System-management interrupt request |
| irq_sci | output | 1 | System-control interrupt request |
| irq_apic | output | 1 | APIC interrupt request |

## Verification
The assertions rely on a few properties of the inputs:

- sts_clr arrives as a pulse.
- The three selectable resets change synchronously to the clock and are held for at least one full cycle.
- Power-good reset is the only asynchronous input apart from pad_in.

The detector treats any change of the inverted level as a possible edge, including a change made by flipping the invert bit. The stimulus therefore passes through trigger off between edge modes, and flips the invert bit only at a pad level where the flip cannot look like a qualifying edge. All inputs change a few nanoseconds after a clock edge. Each reset pulse spans one whole edge.

// File: rtl/gpad_pkg.sv
package gpad_pkg;

    // Bit positions inside configuration word 0 (software decodes these)
    localparam int W0_TXVAL     = 0;
    localparam int W0_RXLVL     = 1;
    localparam int W0_TXDIS     = 8;
    localparam int W0_RXDIS     = 9;
    localparam int W0_MODE_LSB  = 10;
    localparam int W0_ROUTE_LSB = 17;
    localparam int W0_INV       = 23;
    localparam int W0_TRIG_LSB  = 25;
    localparam int W0_DOM_LSB   = 30;

    localparam int CFG_W   = 32;
    localparam int MODE_W  = 3;
    localparam int ROUTE_N = 4;

    // Writable bits of word 0 and its value after a configuration reset
    localparam logic [CFG_W-1:0] W0_WMASK   = 32'hC69E_1F01;
    localparam logic [CFG_W-1:0] W0_DEFAULT = 32'h0400_0100;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'd0,
        TRIG_SINGLE = 2'd1,
        TRIG_OFF    = 2'd2,
        TRIG_BOTH   = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        DOM_PWRGOOD = 2'd0,
        DOM_DEEP    = 2'd1,
        DOM_PLAT    = 2'd2,
        DOM_RESUME  = 2'd3
    } dom_e;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_LEVEL,
        EV_ARMED,
        EV_LATCHED
    } ev_state_e;

endpackage

// File: rtl/gpad_cfg_regs.sv
module gpad_cfg_regs
    import gpad_pkg::*;
(
    input  logic             clk,
    input  logic             pwrgood_rst_n,
    input  logic             deep_rst_n,
    input  logic             plat_rst_n,
    input  logic             resume_rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] word0_q,
    output logic [CFG_W-1:0] word1_q
);

    logic dom_clear;

    // Pick the reset source named by the stored domain field
    always_comb begin
        unique case (dom_e'(word0_q[W0_DOM_LSB +: 2]))
            DOM_DEEP:    dom_clear = !deep_rst_n;
            DOM_PLAT:    dom_clear = !plat_rst_n;
            DOM_RESUME:  dom_clear = !resume_rst_n;
            default:     dom_clear = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge pwrgood_rst_n) begin
        if (!pwrgood_rst_n) begin
            word0_q <= W0_DEFAULT;
            word1_q <= '0;
        end else if (dom_clear) begin
            word0_q <= W0_DEFAULT;
            word1_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                word1_q <= wdata;
            end else begin
                word0_q <= wdata & W0_WMASK;
            end
        end
    end

    AST_DOMAIN_CLEAR: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        ((word0_q[W0_DOM_LSB +: 2] == 2'd1 && !deep_rst_n) ||
         (word0_q[W0_DOM_LSB +: 2] == 2'd2 && !plat_rst_n) ||
         (word0_q[W0_DOM_LSB +: 2] == 2'd3 && !resume_rst_n))
        |=> (word0_q == W0_DEFAULT && word1_q == '0)); // R11

    AST_CONFIG_STABLE: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (!wr_en && deep_rst_n && plat_rst_n && resume_rst_n)
        |=> ($stable(word0_q) && $stable(word1_q))); // R11

endmodule

// File: rtl/gpad_rx_sync.sv
module gpad_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES < 2) begin : g_single
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gpad_pad_mux.sv
module gpad_pad_mux
    import gpad_pkg::*;
#(
    parameter int NUM_NF = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              txdis,
    input  logic              txval,
    input  logic              rx_lvl,
    input  logic [NUM_NF-1:0] nf_tx,
    input  logic [NUM_NF-1:0] nf_oe,
    output logic [NUM_NF-1:0] nf_rx,
    output logic              pad_out,
    output logic              pad_oe
);

    logic [NUM_NF-1:0] sel;
    logic              is_gpio;
    logic              drv_val;
    logic              drv_en;

    generate
        for (genvar gi = 0; gi < NUM_NF; gi++) begin : g_nf
            assign sel[gi]   = (mode == MODE_W'(gi + 1));
            assign nf_rx[gi] = sel[gi] & rx_lvl;
        end
    endgenerate

    assign is_gpio = (mode == '0);

    always_comb begin
        if (is_gpio) begin
            drv_val = txval;
            drv_en  = 1'b1;
        end else begin
            drv_val = |(sel & nf_tx);
            drv_en  = |(sel & nf_oe);
        end
    end

    assign pad_out = drv_val;
    assign pad_oe  = drv_en & !txdis;

    AST_NF_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nf_rx)); // R3

endmodule

// File: rtl/gpad_evt_fsm.sv
module gpad_evt_fsm
    import gpad_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_lvl,
    input  logic               cfg_inv,
    input  trig_e              cfg_trig,
    input  logic               cfg_rxdis,
    input  logic [ROUTE_N-1:0] cfg_route,
    input  logic               sts_clr,
    output logic               evt_sts,
    output logic [ROUTE_N-1:0] irq
);

    ev_state_e st_q, st_d;
    logic      rx_inv;
    logic      rx_inv_q;
    logic      edge_hit;
    logic      evt;

    assign rx_inv = rx_lvl ^ cfg_inv;

    always_comb begin
        unique case (cfg_trig)
            TRIG_SINGLE: edge_hit = rx_inv & !rx_inv_q;
            TRIG_BOTH:   edge_hit = rx_inv ^ rx_inv_q;
            default:     edge_hit = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (cfg_rxdis || cfg_trig == TRIG_OFF) begin
            st_d = EV_IDLE;
        end else if (cfg_trig == TRIG_LEVEL) begin
            st_d = EV_LEVEL;
        end else begin
            unique case (st_q)
                EV_IDLE, EV_LEVEL: st_d = EV_ARMED;
                EV_ARMED:          if (edge_hit) st_d = EV_LATCHED;
                EV_LATCHED:        if (sts_clr && !edge_hit) st_d = EV_ARMED;
                default:           st_d = EV_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= EV_IDLE;
            rx_inv_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            rx_inv_q <= rx_inv;
        end
    end

    // Outputs
    always_comb begin
        evt_sts = (st_q == EV_LATCHED);
        evt     = evt_sts ||
                  (st_q == EV_LEVEL && cfg_trig == TRIG_LEVEL && !cfg_rxdis && rx_inv);
        irq     = cfg_route & {ROUTE_N{evt}};
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rxdis || cfg_trig == TRIG_OFF) |=> !evt_sts); // R10

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sts && !sts_clr && !cfg_rxdis && cfg_trig inside {TRIG_SINGLE, TRIG_BOTH})
        |=> evt_sts); // R8

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_sts) |-> $past(edge_hit)); // R6

endmodule

// File: rtl/gpad_ctrl.sv
module gpad_ctrl
    import gpad_pkg::*;
#(
    parameter int NUM_NF      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              pwrgood_rst_n,
    input  logic              deep_rst_n,
    input  logic              plat_rst_n,
    input  logic              resume_rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_word0,
    output logic [31:0]       cfg_word1,
    input  logic              sts_clr,
    output logic              evt_sts,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    input  logic [NUM_NF-1:0] nf_tx,
    input  logic [NUM_NF-1:0] nf_oe,
    output logic [NUM_NF-1:0] nf_rx,
    output logic              irq_nmi,
    output logic              irq_smi,
    output logic              irq_sci,
    output logic              irq_apic
);

    logic [CFG_W-1:0]   word0_q;
    logic [CFG_W-1:0]   word1_q;
    logic               rx_raw;
    logic               rx_lvl;
    logic [ROUTE_N-1:0] irq_vec;

    gpad_cfg_regs i_cfg (
        .clk           (clk),
        .pwrgood_rst_n (pwrgood_rst_n),
        .deep_rst_n    (deep_rst_n),
        .plat_rst_n    (plat_rst_n),
        .resume_rst_n  (resume_rst_n),
        .wr_en         (cfg_wr_en),
        .wr_sel        (cfg_wr_sel),
        .wdata         (cfg_wdata),
        .word0_q       (word0_q),
        .word1_q       (word1_q)
    );

    gpad_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (pwrgood_rst_n),
        .d     (pad_in),
        .q     (rx_raw)
    );

    assign rx_lvl = rx_raw & !word0_q[W0_RXDIS];

    gpad_pad_mux #(.NUM_NF(NUM_NF)) i_mux (
        .clk     (clk),
        .rst_n   (pwrgood_rst_n),
        .mode    (word0_q[W0_MODE_LSB +: MODE_W]),
        .txdis   (word0_q[W0_TXDIS]),
        .txval   (word0_q[W0_TXVAL]),
        .rx_lvl  (rx_lvl),
        .nf_tx   (nf_tx),
        .nf_oe   (nf_oe),
        .nf_rx   (nf_rx),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpad_evt_fsm i_evt (
        .clk       (clk),
        .rst_n     (pwrgood_rst_n),
        .rx_lvl    (rx_lvl),
        .cfg_inv   (word0_q[W0_INV]),
        .cfg_trig  (trig_e'(word0_q[W0_TRIG_LSB +: 2])),
        .cfg_rxdis (word0_q[W0_RXDIS]),
        .cfg_route (word0_q[W0_ROUTE_LSB +: ROUTE_N]),
        .sts_clr   (sts_clr),
        .evt_sts   (evt_sts),
        .irq       (irq_vec)
    );

    assign cfg_word0 = word0_q | (CFG_W'(rx_lvl) << W0_RXLVL);
    assign cfg_word1 = word1_q;

    assign irq_nmi  = irq_vec[0];
    assign irq_smi  = irq_vec[1];
    assign irq_sci  = irq_vec[2];
    assign irq_apic = irq_vec[3];

endmodule

// File: tb/test_gpad_ctrl.sv
`timescale 1ns/1ps
module test_gpad_ctrl;

    localparam real TCLK = 8.0;

    logic        clk = 1'b0;
    logic        pwrgood_rst_n = 1'b0;
    logic        deep_rst_n = 1'b1;
    logic        plat_rst_n = 1'b1;
    logic        resume_rst_n = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_word0;
    logic [31:0] cfg_word1;
    logic        sts_clr = 1'b0;
    logic        evt_sts;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_oe;
    logic [5:0]  nf_tx = '0;
    logic [5:0]  nf_oe = '0;
    logic [5:0]  nf_rx;
    logic        irq_nmi, irq_smi, irq_sci, irq_apic;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    gpad_ctrl i_gpad_ctrl (
        .clk(clk), .pwrgood_rst_n(pwrgood_rst_n), .deep_rst_n(deep_rst_n),
        .plat_rst_n(plat_rst_n), .resume_rst_n(resume_rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wdata(cfg_wdata),
        .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
        .sts_clr(sts_clr), .evt_sts(evt_sts),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .nf_tx(nf_tx), .nf_oe(nf_oe), .nf_rx(nf_rx),
        .irq_nmi(irq_nmi), .irq_smi(irq_smi), .irq_sci(irq_sci), .irq_apic(irq_apic)
    );

    function automatic logic [31:0] irqs();
        return {28'd0, irq_apic, irq_sci, irq_smi, irq_nmi};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wdata = data;
        step(1);
        cfg_wr_en = 1'b0; cfg_wr_sel = 1'b0;
    endtask

    task automatic clr_pulse();
        sts_clr = 1'b1;
        step(1);
        sts_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 word0 default", cfg_word0, 32'h0400_0100);
        check("R1 word1 default", cfg_word1, 32'h0);
        check("R1 pad_oe off", 32'(pad_oe), 32'h0);
        check("R1 irqs quiet", irqs(), 32'h0);
        check("R1 status clear", 32'(evt_sts), 32'h0);
    endtask

    task automatic t_gpio_out();
        wr(1'b0, 32'h0400_0001);
        check("R2 drive high", {30'd0, pad_oe, pad_out}, 32'h3);
        wr(1'b0, 32'h0400_0000);
        check("R2 drive low", {30'd0, pad_oe, pad_out}, 32'h2);
        wr(1'b0, 32'h0400_0101);
        check("R2 driver disabled", 32'(pad_oe), 32'h0);
    endtask

    task automatic t_native();
        nf_tx = 6'b000100; nf_oe = 6'b000100;
        wr(1'b0, 32'h0400_0C00);
        check("R3 nf3 drives high", {30'd0, pad_oe, pad_out}, 32'h3);
        nf_tx = 6'b111011;
        #1;
        check("R3 nf3 drives low", {30'd0, pad_oe, pad_out}, 32'h2);
        pad_in = 1'b1;
        step(2);
        check("R3 rx to nf3 only", 32'(nf_rx), 32'h04);
        check("R4 readback bit1 in native mode", cfg_word0, 32'h0400_0C02);
        wr(1'b0, 32'h0400_1C00);
        check("R3 mode7 no drive", {30'd0, pad_oe, pad_out}, 32'h0);
        check("R3 mode7 no rx", 32'(nf_rx), 32'h0);
        wr(1'b0, 32'h0400_0D00);
        check("R3 native with output disable", 32'(pad_oe), 32'h0);
        pad_in = 1'b0; nf_tx = '0; nf_oe = '0;
        wr(1'b0, 32'h0400_0100);
        step(2);
    endtask

    task automatic t_rx_readback();
        wr(1'b0, 32'h0D20_2006);
        check("R4 reserved and bit1 ignored", cfg_word0, 32'h0400_0000);
        pad_in = 1'b1;
        step(1);
        check("R4 one edge not yet seen", cfg_word0, 32'h0400_0000);
        step(1);
        check("R4 level after two edges", cfg_word0, 32'h0400_0002);
        wr(1'b0, 32'h0400_0200);
        check("R4 input disabled reads 0", cfg_word0, 32'h0400_0200);
        pad_in = 1'b0;
        wr(1'b0, 32'h0400_0100);
        step(2);
    endtask

    task automatic t_level();
        wr(1'b0, 32'h0002_0100);
        step(1);
        check("R5 level low", irqs(), 32'h0);
        pad_in = 1'b1;
        step(1);
        check("R5 level not yet", irqs(), 32'h0);
        step(1);
        check("R5 level high to nmi", irqs(), 32'h1);
        wr(1'b0, 32'h0082_0100);
        check("R5 inverted high input", irqs(), 32'h0);
        pad_in = 1'b0;
        step(2);
        check("R5 inverted low input", irqs(), 32'h1);
        wr(1'b0, 32'h0400_0100);
        step(1);
        check("R10 trigger off drops level", irqs(), 32'h0);
    endtask

    task automatic t_single();
        wr(1'b0, 32'h0204_0100);
        step(1);
        check("R6 armed clear", 32'(evt_sts), 32'h0);
        pad_in = 1'b1;
        step(3);
        check("R6 rising sets status", 32'(evt_sts), 32'h1);
        check("R9 smi only", irqs(), 32'h2);
        clr_pulse();
        check("R8 clear pulse", {evt_sts, irqs()}, 32'h0);
        pad_in = 1'b0;
        step(3);
        check("R6 falling ignored without invert", 32'(evt_sts), 32'h0);
        pad_in = 1'b1;
        step(3);
        check("R6 rising sets again", 32'(evt_sts), 32'h1);
        clr_pulse();
        wr(1'b0, 32'h0284_0100);
        step(1);
        check("R6 invert switch quiet", 32'(evt_sts), 32'h0);
        pad_in = 1'b0;
        step(3);
        check("R6 falling sets with invert", 32'(evt_sts), 32'h1);
        clr_pulse();
        pad_in = 1'b1;
        step(3);
        check("R6 rising ignored with invert", 32'(evt_sts), 32'h0);
        wr(1'b0, 32'h0400_0100);
        step(1);
    endtask

    task automatic t_both();
        wr(1'b0, 32'h0608_0100);
        step(1);
        check("R7 armed clear", 32'(evt_sts), 32'h0);
        pad_in = 1'b0;
        step(3);
        check("R7 falling sets", 32'(evt_sts), 32'h1);
        check("R9 sci only", irqs(), 32'h4);
        clr_pulse();
        pad_in = 1'b1;
        step(3);
        check("R7 rising sets", 32'(evt_sts), 32'h1);
        clr_pulse();
        wr(1'b0, 32'h0400_0100);
        step(1);
    endtask

    task automatic t_routes_race();
        wr(1'b0, 32'h061E_0100);
        step(1);
        pad_in = 1'b0;
        step(3);
        check("R9 all four routed", irqs(), 32'hF);
        pad_in = 1'b1;
        step(2);
        sts_clr = 1'b1;
        step(1);
        sts_clr = 1'b0;
        check("R8 edge beats clear", 32'(evt_sts), 32'h1);
        clr_pulse();
        check("R8 clear alone", {evt_sts, irqs()}, 32'h0);
        wr(1'b0, 32'h0400_0100);
        step(1);
    endtask

    task automatic t_quiet();
        wr(1'b0, 32'h061E_0300);
        step(1);
        pad_in = 1'b0;
        step(3);
        check("R10 input disabled no event", {evt_sts, irqs()}, 32'h0);
        pad_in = 1'b1;
        step(3);
        check("R10 input disabled still quiet", {evt_sts, irqs()}, 32'h0);
        wr(1'b0, 32'h009E_0300);
        step(1);
        check("R10 inverted level with input disabled", irqs(), 32'h0);
        wr(1'b0, 32'h0400_0100);
        step(1);
        wr(1'b0, 32'h061E_0100);
        step(1);
        pad_in = 1'b0;
        step(3);
        check("R10 pending before off", 32'(evt_sts), 32'h1);
        wr(1'b0, 32'h041E_0100);
        step(1);
        check("R10 off clears pending", {evt_sts, irqs()}, 32'h0);
        pad_in = 1'b1;
        step(3);
        check("R10 off ignores edge", {evt_sts, irqs()}, 32'h0);
        pad_in = 1'b0;
        step(2);
    endtask

    task automatic t_domains();
        wr(1'b1, 32'h1234_5678);
        wr(1'b0, 32'h4000_0001);
        check("R11 deep domain written", cfg_word0, 32'h4000_0001);
        plat_rst_n = 1'b0; step(1); plat_rst_n = 1'b1;
        resume_rst_n = 1'b0; step(1); resume_rst_n = 1'b1;
        check("R11 other resets ignored", cfg_word0, 32'h4000_0001);
        check("R11 word1 kept", cfg_word1, 32'h1234_5678);
        deep_rst_n = 1'b0; step(1); deep_rst_n = 1'b1;
        check("R11 deep clears word0", cfg_word0, 32'h0400_0100);
        check("R11 deep clears word1", cfg_word1, 32'h0);
        wr(1'b0, 32'h8000_0001);
        deep_rst_n = 1'b0; step(1); deep_rst_n = 1'b1;
        check("R11 platform domain ignores deep", cfg_word0, 32'h8000_0001);
        plat_rst_n = 1'b0; step(1); plat_rst_n = 1'b1;
        check("R11 platform clears", cfg_word0, 32'h0400_0100);
        wr(1'b0, 32'hC000_0001);
        wr(1'b1, 32'hFFFF_0000);
        resume_rst_n = 1'b0; step(1); resume_rst_n = 1'b1;
        check("R11 resume clears", {cfg_word0 ^ 32'h0400_0100} | cfg_word1, 32'h0);
        wr(1'b0, 32'h4000_0001);
        pwrgood_rst_n = 1'b0; step(1); pwrgood_rst_n = 1'b1;
        step(1);
        check("R11 power-good always clears", cfg_word0, 32'h0400_0100);
    endtask

    task automatic t_word1();
        wr(1'b1, 32'hA5C3_0F96);
        check("R12 word1 stored", cfg_word1, 32'hA5C3_0F96);
        check("R12 word0 untouched", cfg_word0, 32'h0400_0100);
    endtask

    initial begin
        step(3);
        pwrgood_rst_n = 1'b1;
        step(2);
        t_reset();
        t_gpio_out();
        t_native();
        t_rx_readback();
        t_level();
        t_single();
        t_both();
        t_routes_race();
        t_quiet();
        t_domains();
        t_word1();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule